// File: doc/BRIEF.md
# Video Input Valid-Area Enable Generator

This block marks the active picture region of an interlaced video input so that only those samples are stored in a frame memory. It runs on the pixel clock. A pixel counter restarts on every rising edge of horizontal sync, and a line counter restarts on every rising edge of vertical sync. Both counters are compared against start offsets set by software, so the stored rectangle stays correctly placed even when the sync pulses arrive with an unusual phase.

Two registered active-low strobes are produced. The write strobe covers the full storage window. The read strobe covers the window that a recursive noise-reduction stage reads back from memory. The two strobes share the same horizontal span but can differ vertically. An extension option lengthens only the write window, and a top-trim option for 525-line input shortens only the read window. The line controls are captured once per field, at the vertical sync edge.

Top module: `vid_area_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first sync edges arrive, both `wr_en_n` and `rd_en_n` stay high (deasserted).
- R2: On the cycle after the clock edge that samples a rising edge on `hsync`, the pixel index is 0. After that it rises by one per clock and holds at 2047.
- R3: The line index becomes 0 at a rising edge of `vsync`. Each later rising edge of `hsync` adds one to it.
- R4: `wr_en_n` is low exactly when h_start <= pixel < h_start + W and v_start <= line < v_start + Lw. It is high everywhere else.
- R5: `hmode` selects the width W: 0 gives 720 pixels, 1 gives 640 and 2 gives 768. Code 3 is reserved for test and behaves as 720.
- R6: `std525` = 0 (625-line input) gives Lw = 288. `std525` = 1 (525-line input) gives Lw = 243.
- R7: With `line_ext` = 1 and `bt656_mode` = 1, Lw becomes 304 (625-line) or 254 (525-line). The read window stays at 288 or 243 lines.
- R8: With `line_ext` = 1 and `bt656_mode` = 0, the extension is ignored and Lw keeps its normal value.
- R9: With `std525` = 1 and `nr_trim` = 1, the read window covers lines v_start+2 through v_start+242 (241 lines). The write window is unchanged. With `std525` = 0, `nr_trim` has no effect.
- R10: `std525`, `bt656_mode`, `line_ext` and `nr_trim` are sampled only at a rising edge of `vsync`. A change made during a field takes effect in the next field.
- R11: `rd_en_n` is low only when `wr_en_n` is also low, and both use the same horizontal span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Horizontal sync; the rising edge starts a line |
| vsync | input | 1 | Vertical sync; the rising edge starts a field |
| h_start | input | 11 | First valid pixel index |
| v_start | input | 10 | First valid line index |
| hmode | input | 2 | Width select (0:720, 1:640, 2:768, 3:reserved) |
| std525 | input | 1 | 0 = 625-line input, 1 = 525-line input |
| bt656_mode | input | 1 | Input is in embedded-sync digital mode |
| line_ext | input | 1 | Lengthen the write window (only in embedded-sync mode) |
| nr_trim | input | 1 | Drop the two top lines of the read window (525-line only) |
| wr_en_n | output | 1 | Active-low frame-memory write strobe |
| rd_en_n | output | 1 | Active-low noise-reduction read strobe |

## Verification
The bench measures the first valid line and the line count of each strobe in every mode combination. A mistake in the extension gating, for example applying it outside embedded-sync mode or also to the read window, shows up directly as a wrong count. The trim case checks that the read window starts two lines later while the write window does not move; a design that trimmed the bottom instead, or trimmed both windows, would report a different first line. A mid-field control change must not alter the current field's count, which catches a design that reads the controls live. Horizontal sweeps over one long line check the first pixel and the width for every width code, including the reserved one, and check that the counters come out of reset parked outside the window.

// File: rtl/vag_pkg.sv
package vag_pkg;

    typedef enum logic [1:0] {
        HM_720  = 2'd0,
        HM_640  = 2'd1,
        HM_768  = 2'd2,
        HM_RSVD = 2'd3
    } hmode_e;

    // line-window controls captured at each field start
    typedef struct packed {
        logic std525;
        logic bt656;
        logic ext;
        logic trim;
    } vcfg_t;

endpackage

// File: rtl/vag_hcount.sv
module vag_hcount #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hsync,
    output logic [CW-1:0] pix_nxt,
    output logic          line_edge
);
    localparam logic [CW-1:0] CMAX = '1;

    typedef struct packed {
        logic          hs;
        logic [CW-1:0] cnt;
    } hstate_t;

    hstate_t s_d, s_q;

    assign line_edge = hsync & ~s_q.hs;

    always_comb begin
        s_d    = s_q;
        s_d.hs = hsync;
        if (line_edge) begin
            s_d.cnt = '0;
        end else if (s_q.cnt != CMAX) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.hs  <= 1'b1;
            s_q.cnt <= CMAX;
        end else begin
            s_q <= s_d;
        end
    end

    assign pix_nxt = s_d.cnt;

    // R2: a sampled sync edge restarts the pixel index at zero
    a_r2_line_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync && !s_q.hs) |=> (s_q.cnt == '0));

    // R2: a parked counter stays parked until the next sync edge
    a_r2_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
        (!(hsync && !s_q.hs) && s_q.cnt == CMAX) |=> (s_q.cnt == CMAX));

endmodule

// File: rtl/vag_vcount.sv
module vag_vcount
    import vag_pkg::*;
#(
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vsync,
    input  logic          line_edge,
    input  vcfg_t         cfg_in,
    output logic [LW-1:0] line_nxt,
    output vcfg_t         cfg_nxt
);
    localparam logic [LW-1:0] LMAX = '1;

    typedef struct packed {
        logic          vs;
        logic [LW-1:0] cnt;
        vcfg_t         cfg;
    } vstate_t;

    vstate_t s_d, s_q;
    logic    field_edge;

    assign field_edge = vsync & ~s_q.vs;

    always_comb begin
        s_d    = s_q;
        s_d.vs = vsync;
        if (field_edge) begin
            s_d.cnt = '0;
            s_d.cfg = cfg_in;
        end else if (line_edge && s_q.cnt != LMAX) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.vs  <= 1'b1;
            s_q.cnt <= LMAX;
            s_q.cfg <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign line_nxt = s_d.cnt;
    assign cfg_nxt  = s_d.cfg;

    // R10: controls only change at a field boundary
    a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(vsync && !s_q.vs) |=> $stable(s_q.cfg));

    // R3: field start puts the line index at zero
    a_r3_field_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && !s_q.vs) |=> (s_q.cnt == '0));

endmodule

// File: rtl/vag_window.sv
module vag_window
    import vag_pkg::*;
#(
    parameter int CW         = 11,
    parameter int LW         = 10,
    parameter int PIX_A      = 720,
    parameter int PIX_B      = 640,
    parameter int PIX_C      = 768,
    parameter int LINES_625  = 288,
    parameter int LINES_525  = 243,
    parameter int EXT_625    = 304,
    parameter int EXT_525    = 254,
    parameter int TRIM_LINES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] pix_nxt,
    input  logic [LW-1:0] line_nxt,
    input  vcfg_t         cfg_nxt,
    input  logic [1:0]    hmode,
    input  logic [CW-1:0] h_start,
    input  logic [LW-1:0] v_start,
    output logic          wr_en_n,
    output logic          rd_en_n
);
    typedef struct packed {
        logic wr_n;
        logic rd_n;
    } en_t;

    en_t en_d, en_q;

    int  pix_i, line_i, hs_i, vs_i;
    int  width, wr_len, rd_len, rd_skip;
    logic h_in, v_wr, v_rd;

    always_comb begin
        pix_i  = int'(pix_nxt);
        line_i = int'(line_nxt);
        hs_i   = int'(h_start);
        vs_i   = int'(v_start);

        case (hmode_e'(hmode))
            HM_640:  width = PIX_B;
            HM_768:  width = PIX_C;
            default: width = PIX_A;
        endcase

        if (cfg_nxt.std525) begin
            rd_len  = LINES_525;
            wr_len  = (cfg_nxt.ext && cfg_nxt.bt656) ? EXT_525 : LINES_525;
            rd_skip = cfg_nxt.trim ? TRIM_LINES : 0;
        end else begin
            rd_len  = LINES_625;
            wr_len  = (cfg_nxt.ext && cfg_nxt.bt656) ? EXT_625 : LINES_625;
            rd_skip = 0;
        end

        h_in = (pix_i >= hs_i) && (pix_i < hs_i + width);
        v_wr = (line_i >= vs_i) && (line_i < vs_i + wr_len);
        v_rd = (line_i >= vs_i + rd_skip) && (line_i < vs_i + rd_len);

        en_d.wr_n = !(h_in && v_wr);
        en_d.rd_n = !(h_in && v_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '{wr_n: 1'b1, rd_n: 1'b1};
        end else begin
            en_q <= en_d;
        end
    end

    assign wr_en_n = en_q.wr_n;
    assign rd_en_n = en_q.rd_n;

    // R1: strobes come out of reset deasserted
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (wr_en_n && rd_en_n));

    // R11: read strobe lies inside the write strobe
    a_r11_rd_in_wr: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_n |-> !wr_en_n);

endmodule

// File: rtl/vid_area_gen.sv
module vid_area_gen
    import vag_pkg::*;
#(
    parameter int HCNT_W     = 11,
    parameter int VCNT_W     = 10,
    parameter int PIX_A      = 720,
    parameter int PIX_B      = 640,
    parameter int PIX_C      = 768,
    parameter int LINES_625  = 288,
    parameter int LINES_525  = 243,
    parameter int EXT_625    = 304,
    parameter int EXT_525    = 254,
    parameter int TRIM_LINES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              vsync,
    input  logic [HCNT_W-1:0] h_start,
    input  logic [VCNT_W-1:0] v_start,
    input  logic [1:0]        hmode,
    input  logic              std525,
    input  logic              bt656_mode,
    input  logic              line_ext,
    input  logic              nr_trim,
    output logic              wr_en_n,
    output logic              rd_en_n
);
    logic [HCNT_W-1:0] pix_nxt;
    logic [VCNT_W-1:0] line_nxt;
    logic              line_edge;
    vcfg_t             cfg_in, cfg_nxt;

    assign cfg_in = '{std525: std525, bt656: bt656_mode, ext: line_ext, trim: nr_trim};

    vag_hcount #(.CW(HCNT_W)) u_hcount (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync     (hsync),
        .pix_nxt   (pix_nxt),
        .line_edge (line_edge)
    );

    vag_vcount #(.LW(VCNT_W)) u_vcount (
        .clk       (clk),
        .rst_n     (rst_n),
        .vsync     (vsync),
        .line_edge (line_edge),
        .cfg_in    (cfg_in),
        .line_nxt  (line_nxt),
        .cfg_nxt   (cfg_nxt)
    );

    vag_window #(
        .CW(HCNT_W), .LW(VCNT_W),
        .PIX_A(PIX_A), .PIX_B(PIX_B), .PIX_C(PIX_C),
        .LINES_625(LINES_625), .LINES_525(LINES_525),
        .EXT_625(EXT_625), .EXT_525(EXT_525),
        .TRIM_LINES(TRIM_LINES)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_nxt  (pix_nxt),
        .line_nxt (line_nxt),
        .cfg_nxt  (cfg_nxt),
        .hmode    (hmode),
        .h_start  (h_start),
        .v_start  (v_start),
        .wr_en_n  (wr_en_n),
        .rd_en_n  (rd_en_n)
    );

endmodule

// File: tb/test_vid_area_gen.sv
module test_vid_area_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync = 1'b0;
    logic        vsync = 1'b0;
    logic [10:0] h_start = 11'd0;
    logic [9:0]  v_start = 10'd0;
    logic [1:0]  hmode = 2'd0;
    logic        std525 = 1'b0;
    logic        bt656_mode = 1'b0;
    logic        line_ext = 1'b0;
    logic        nr_trim = 1'b0;
    logic        wr_en_n, rd_en_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    vid_area_gen i_vid_area_gen (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .h_start(h_start), .v_start(v_start), .hmode(hmode),
        .std525(std525), .bt656_mode(bt656_mode), .line_ext(line_ext),
        .nr_trim(nr_trim), .wr_en_n(wr_en_n), .rd_en_n(rd_en_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    // one-cycle sync pulse; returns at the negedge where pixel index is 0
    task automatic pulse_line(input bit with_vs);
        @(negedge clk);
        hsync = 1'b1;
        vsync = with_vs;
        @(negedge clk);
        hsync = 1'b0;
        vsync = 1'b0;
    endtask

    // short lines: sample pixel 3 of each line, h_start = 2
    task automatic run_field(input int nl, input int chg,
                             output int wf, output int wc,
                             output int rf, output int rc, output int viol);
        wf = -1; wc = 0; rf = -1; rc = 0; viol = 0;
        for (int l = 0; l < nl; l++) begin
            pulse_line(l == 0);
            if (l == chg) begin
                line_ext   = 1'b1;
                bt656_mode = 1'b1;
            end
            repeat (3) @(negedge clk);
            if (!wr_en_n) begin
                if (wf < 0) wf = l;
                wc++;
            end
            if (!rd_en_n) begin
                if (rf < 0) rf = l;
                rc++;
            end
            if (!rd_en_n && wr_en_n) viol++;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic t_field(input string tag, input bit s525, input bit b656,
                           input bit ext, input bit trim,
                           input int ew, input int erf, input int erc);
        int wf, wc, rf, rc, viol;
        std525 = s525; bt656_mode = b656; line_ext = ext; nr_trim = trim;
        h_start = 11'd2; v_start = 10'd5; hmode = 2'd0;
        run_field(320, -1, wf, wc, rf, rc, viol);
        chk({tag, " R4 write first line"}, wf, 5);
        chk({tag, " write line count"}, wc, ew);
        chk({tag, " read first line"}, rf, erf);
        chk({tag, " read line count"}, rc, erc);
        chk({tag, " R11 read outside write"}, viol, 0);
    endtask

    // one long line at line 0: sweep pixels 0..899
    task automatic t_hor(input string tag, input logic [1:0] m, input int ew);
        int wf, wc, rc;
        wf = -1; wc = 0; rc = 0;
        std525 = 1'b0; bt656_mode = 1'b0; line_ext = 1'b0; nr_trim = 1'b0;
        hmode = m; h_start = 11'd100; v_start = 10'd0;
        pulse_line(1'b1);
        for (int j = 0; j < 900; j++) begin
            if (!wr_en_n) begin
                if (wf < 0) wf = j;
                wc++;
            end
            if (!rd_en_n) rc++;
            @(negedge clk);
        end
        chk({tag, " R2 first valid pixel"}, wf, 100);
        chk({tag, " R5 write width"}, wc, ew);
        chk({tag, " R11 read width"}, rc, ew);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 wr during reset", int'(wr_en_n), 1);
        chk("R1 rd during reset", int'(rd_en_n), 1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 wr idle before sync", int'(wr_en_n), 1);
        chk("R1 rd idle before sync", int'(rd_en_n), 1);
    endtask

    task automatic t_midfield();
        int wf, wc, rf, rc, viol;
        std525 = 1'b0; bt656_mode = 1'b0; line_ext = 1'b0; nr_trim = 1'b0;
        h_start = 11'd2; v_start = 10'd5; hmode = 2'd0;
        run_field(320, 10, wf, wc, rf, rc, viol);
        chk("R10 mid-field change ignored", wc, 288);
        run_field(320, -1, wf, wc, rf, rc, viol);
        chk("R10 change applied next field", wc, 304);
        chk("R10 next field read lines", rc, 288);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_hor("hmode0", 2'd0, 720);
        t_hor("hmode1", 2'd1, 640);
        t_hor("hmode2", 2'd2, 768);
        t_hor("hmode3 reserved", 2'd3, 720);
        t_field("R6 R3 625", 1'b0, 1'b0, 1'b0, 1'b0, 288, 5, 288);
        t_field("R6 525", 1'b1, 1'b0, 1'b0, 1'b0, 243, 5, 243);
        t_field("R7 625 ext", 1'b0, 1'b1, 1'b1, 1'b0, 304, 5, 288);
        t_field("R7 525 ext", 1'b1, 1'b1, 1'b1, 1'b0, 254, 5, 243);
        t_field("R8 625 ext no656", 1'b0, 1'b0, 1'b1, 1'b0, 288, 5, 288);
        t_field("R8 525 ext no656", 1'b1, 1'b0, 1'b1, 1'b0, 243, 5, 243);
        t_field("R9 525 trim", 1'b1, 1'b0, 1'b0, 1'b1, 243, 7, 241);
        t_field("R9 625 trim ignored", 1'b0, 1'b0, 1'b0, 1'b1, 288, 5, 288);
        t_midfield();
        done = 1'b1;
        report();
        $finish;
    end

endmodule